// File: doc/BRIEF.md
# Low-voltage detector control register

This block is the control and status byte of a supply-voltage monitor. Software reads one byte that reports three things. The top bit is a rewrite-enable flag, which decides whether the detection-level register elsewhere may be written. Bit 1 is a mask-status bit. Bit 0 is a detection flag, which is set while the supply sits below the chosen threshold.

The block also gates the monitor's reset and interrupt requests. It suppresses both requests while the threshold is open for rewriting. It also suppresses them while the threshold is settling, which happens after a detector interrupt and after a change of level selection. A settling window closes on a one-cycle stabilization-done pulse from an external timer.

The reset behaviour depends on where the reset came from. A reset raised by the detector itself keeps the rewrite-enable bit. Any other reset source clears the whole byte. The bus offers a byte write and a single-bit write, which carries a bit index and a bit value.

Top module: `lvd_ctrl_reg`

## Requirements
- R1: The readback byte `rd_data` holds the fields in this order: rewrite-enable at bit 7, zeros at bits 6 to 2, mask status at bit 1, and detection flag at bit 0.
- R2: A write to bits 6 to 0 has no effect on the readback. This holds for a byte write (`bus_we`) and for a single-bit write (`bus_bwe` with `bus_bidx` from 0 to 6).
- R3: A synchronous reset `rst` with `rst_by_det` = 0 sets the readback to 0x00. When `rst_by_det` = 1, bit 7 keeps its value and the rest of the state clears.
- R4: A write of 1 to bit 7 takes effect only when `opt_mode` = 2'b10. In any other mode it leaves bit 7 unchanged. A write of 0 clears bit 7 in any mode.
- R5: `lvl_wr_allow` equals bit 7, and it blocks writes to the detection level while bit 7 is 0.
- R6: While `det_en` = 1, bit 0 follows `cmp_raw` (1 = supply below the level) two clock edges later. While `det_en` = 0, bit 0 reads 0.
- R7: While bit 7 is 1, the mask status reads 1.
- R8: A pulse on `det_irq_in` sets the mask status from the next cycle until a `stab_done` pulse.
- R9: A pulse on `lvl_chg` sets the mask status from the next cycle until a `stab_done` pulse.
- R10: The mask status falls in the cycle after `stab_done` when no masking cause remains. If a new `lvl_chg` or `det_irq_in` arrives in the same cycle as `stab_done`, the window restarts and the mask stays at 1.
- R11: While the mask status is 1, `irq_out` and `rst_out` are 0. While it is 0, they pass `det_irq_in` and `det_rst_in` in the same cycle.
- R12: A single-bit write changes only the bit that `bus_bidx` addresses. If a byte write and a single-bit write arrive together, the byte write wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| rst_by_det | input | 1 | Marks the current reset as raised by the detector |
| bus_we | input | 1 | Byte write strobe |
| bus_wdata | input | 8 | Byte write data |
| bus_bwe | input | 1 | Single-bit write strobe |
| bus_bidx | input | 3 | Bit index for a single-bit write |
| bus_bval | input | 1 | Bit value for a single-bit write |
| cmp_raw | input | 1 | Asynchronous comparator result, 1 = supply below the level |
| det_en | input | 1 | Detector enable |
| opt_mode | input | 2 | Option mode bits; 2'b10 = interrupt-and-reset mode |
| lvl_chg | input | 1 | Pulse when the level selection changes |
| stab_done | input | 1 | Pulse when the detection level has settled |
| det_irq_in | input | 1 | Interrupt request from the detector |
| det_rst_in | input | 1 | Reset request from the detector |
| rd_data | output | 8 | Readback byte |
| lvl_wr_allow | output | 1 | Permission to write the detection-level register |
| irq_out | output | 1 | Masked interrupt request |
| rst_out | output | 1 | Masked reset request |

## Verification
Two pairs of events can arrive in the same clock and compete.

The first pair is a settling window ending while a new masking cause begins. The bench drives `stab_done` together with `lvl_chg` in one cycle. It then expects the mask status to stay at 1 after that edge and to fall only after a later, lone `stab_done`. The bench also ends a window while the rewrite-enable bit is still set, and expects the mask to stay up.

The second pair is a byte write and a single-bit write in the same cycle. Here the bench expects the byte value to decide bit 7.

// File: rtl/lvd_ctrl_reg.sv
module lvd_ctrl_reg (
  input  logic       clk,
  input  logic       rst,
  input  logic       rst_by_det,
  input  logic       bus_we,
  input  logic [7:0] bus_wdata,
  input  logic       bus_bwe,
  input  logic [2:0] bus_bidx,
  input  logic       bus_bval,
  input  logic       cmp_raw,
  input  logic       det_en,
  input  logic [1:0] opt_mode,
  input  logic       lvl_chg,
  input  logic       stab_done,
  input  logic       det_irq_in,
  input  logic       det_rst_in,
  output logic [7:0] rd_data,
  output logic       lvl_wr_allow,
  output logic       irq_out,
  output logic       rst_out
);

  localparam logic [1:0] MODE_IRQ_RST = 2'b10;
  localparam logic [2:0] WEN_BIT      = 3'd7;

  logic wen, sync1, sync2, irq_wait, lvl_wait;
  logic wr_hit, wr_val, mode_ok, mask, flag;
  logic unused_wdata;

  assign unused_wdata = ^bus_wdata[6:0];

  assign mode_ok = (opt_mode == MODE_IRQ_RST);
  assign wr_hit  = bus_we | (bus_bwe & (bus_bidx == WEN_BIT));
  assign wr_val  = bus_we ? bus_wdata[7] : bus_bval;

  always_ff @(posedge clk) begin
    if (rst) begin
      if (!rst_by_det) wen <= 1'b0;
    end else if (wr_hit) begin
      wen <= wr_val & (wen | mode_ok);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      sync1    <= 1'b0;
      sync2    <= 1'b0;
      irq_wait <= 1'b0;
      lvl_wait <= 1'b0;
    end else begin
      sync1    <= cmp_raw;
      sync2    <= sync1;
      irq_wait <= det_irq_in | (irq_wait & ~stab_done);
      lvl_wait <= lvl_chg    | (lvl_wait & ~stab_done);
    end
  end

  assign mask         = wen | irq_wait | lvl_wait;
  assign flag         = det_en & sync2;
  assign rd_data      = {wen, 5'b00000, mask, flag};
  assign lvl_wr_allow = wen;
  assign irq_out      = det_irq_in & ~mask;
  assign rst_out      = det_rst_in & ~mask;

  a_r3_plain_reset_clears: assert property (@(posedge clk)
    (rst && !rst_by_det) |=> (rd_data[7] == 1'b0));

  a_r4_set_needs_mode: assert property (@(posedge clk) disable iff (rst)
    $rose(rd_data[7]) |-> ($past(opt_mode) == MODE_IRQ_RST));

  a_r8_irq_opens_window: assert property (@(posedge clk) disable iff (rst)
    det_irq_in |=> rd_data[1]);

  a_r9_lvl_opens_window: assert property (@(posedge clk) disable iff (rst)
    lvl_chg |=> rd_data[1]);

  a_r10_mask_release: assert property (@(posedge clk) disable iff (rst)
    (stab_done && !lvl_chg && !det_irq_in && !bus_we && !bus_bwe && !rd_data[7])
      |=> !rd_data[1]);

  a_r11_outputs_quiet: assert property (@(posedge clk) disable iff (rst)
    rd_data[1] |-> (!irq_out && !rst_out));

endmodule

// File: tb/sim_lvd_ctrl_reg.sv
module sim_lvd_ctrl_reg;
  logic clk = 1'b0;
  logic rst = 1'b1, rst_by_det = 1'b0;
  logic bus_we = 1'b0, bus_bwe = 1'b0, bus_bval = 1'b0;
  logic [7:0] bus_wdata = 8'h00;
  logic [2:0] bus_bidx = 3'd0;
  logic cmp_raw = 1'b0, det_en = 1'b0;
  logic [1:0] opt_mode = 2'b00;
  logic lvl_chg = 1'b0, stab_done = 1'b0, det_irq_in = 1'b0, det_rst_in = 1'b0;
  logic [7:0] rd_data;
  logic lvl_wr_allow, irq_out, rst_out;
  int n_chk = 0, n_fail = 0;

  always #10 clk = ~clk;

  lvd_ctrl_reg u0 (
    .clk(clk), .rst(rst), .rst_by_det(rst_by_det),
    .bus_we(bus_we), .bus_wdata(bus_wdata), .bus_bwe(bus_bwe),
    .bus_bidx(bus_bidx), .bus_bval(bus_bval),
    .cmp_raw(cmp_raw), .det_en(det_en), .opt_mode(opt_mode),
    .lvl_chg(lvl_chg), .stab_done(stab_done),
    .det_irq_in(det_irq_in), .det_rst_in(det_rst_in),
    .rd_data(rd_data), .lvl_wr_allow(lvl_wr_allow),
    .irq_out(irq_out), .rst_out(rst_out)
  );

  // {opt_mode, write byte, expected readback}
  localparam logic [17:0] VEC [7] = '{
    {2'b10, 8'h80, 8'h82},
    {2'b10, 8'h00, 8'h00},
    {2'b00, 8'hFF, 8'h00},
    {2'b01, 8'h80, 8'h00},
    {2'b11, 8'h83, 8'h00},
    {2'b10, 8'hFF, 8'h82},
    {2'b00, 8'h03, 8'h00}
  };

  task automatic chk(input string req, input logic [7:0] got, input logic [7:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %02h expected %02h", req, got, exp);
    end
  endtask

  task automatic wr_byte(input logic [7:0] d);
    @(negedge clk); bus_we = 1'b1; bus_wdata = d;
    @(negedge clk); bus_we = 1'b0;
  endtask

  task automatic wr_bit(input logic [2:0] idx, input logic v);
    @(negedge clk); bus_bwe = 1'b1; bus_bidx = idx; bus_bval = v;
    @(negedge clk); bus_bwe = 1'b0;
  endtask

  initial begin
    #2000000;
    n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk("R3 reset value", rd_data, 8'h00);
    chk("R11 quiet after reset", {6'b0, irq_out, rst_out}, 8'h00);

    for (int i = 0; i < 7; i++) begin
      opt_mode = VEC[i][17:16];
      wr_byte(VEC[i][15:8]);
      chk("R4/R1/R2/R7 table", rd_data, VEC[i][7:0]);
      chk("R5 level write permission", {7'b0, lvl_wr_allow}, {7'b0, VEC[i][7]});
    end

    // R6: two-edge synchronization and enable gating
    det_en = 1'b1;
    @(negedge clk); cmp_raw = 1'b1;
    @(negedge clk); chk("R6 one edge", rd_data, 8'h00);
    @(negedge clk); chk("R6 two edges", rd_data, 8'h01);
    det_en = 1'b0; #1 chk("R6 disabled", rd_data, 8'h00);
    det_en = 1'b1; #1 chk("R6 reenabled", rd_data, 8'h01);

    // R2/R12: single-bit writes
    opt_mode = 2'b10;
    wr_bit(3'd0, 1'b0); chk("R2 bit0 write ignored", rd_data, 8'h01);
    wr_bit(3'd7, 1'b1); chk("R12 bit7 set", rd_data, 8'h83);
    wr_bit(3'd1, 1'b0); chk("R2 bit1 write ignored", rd_data, 8'h83);
    wr_bit(3'd4, 1'b1); chk("R2 bit4 write ignored", rd_data, 8'h83);
    wr_bit(3'd7, 1'b0); chk("R12 bit7 clear", rd_data, 8'h01);
    @(negedge clk); bus_we = 1'b1; bus_wdata = 8'h80; bus_bwe = 1'b1; bus_bidx = 3'd7; bus_bval = 1'b0;
    @(negedge clk); bus_we = 1'b0; bus_bwe = 1'b0;
    chk("R12 byte write wins", rd_data, 8'h83);
    wr_byte(8'h00);
    cmp_raw = 1'b0; det_en = 1'b0;
    repeat (2) @(negedge clk);
    chk("R6 idle", rd_data, 8'h00);

    // R8/R11: interrupt opens a window
    det_irq_in = 1'b1; det_rst_in = 1'b1; #1
    chk("R11 pass when unmasked", {6'b0, irq_out, rst_out}, 8'h03);
    @(negedge clk); det_irq_in = 1'b0;
    chk("R8 window open", rd_data, 8'h02);
    #1 chk("R11 reset suppressed", {6'b0, irq_out, rst_out}, 8'h00);
    det_irq_in = 1'b1; #1
    chk("R11 irq suppressed", {6'b0, irq_out, rst_out}, 8'h00);
    @(negedge clk); det_irq_in = 1'b0; det_rst_in = 1'b0;
    repeat (3) @(negedge clk);
    chk("R8 window held", rd_data, 8'h02);
    stab_done = 1'b1; @(negedge clk); stab_done = 1'b0;
    chk("R10 window closed", rd_data, 8'h00);

    // R9/R10: level change and collision with stab_done
    lvl_chg = 1'b1; @(negedge clk); lvl_chg = 1'b0;
    chk("R9 window open", rd_data, 8'h02);
    stab_done = 1'b1; lvl_chg = 1'b1; @(negedge clk); stab_done = 1'b0; lvl_chg = 1'b0;
    chk("R10 restart wins", rd_data, 8'h02);
    stab_done = 1'b1; @(negedge clk); stab_done = 1'b0;
    chk("R10 release", rd_data, 8'h00);
    det_rst_in = 1'b1; #1 chk("R11 reset passes", {7'b0, rst_out}, 8'h01);
    det_rst_in = 1'b0;

    // R7/R10: rewrite-enable holds mask through stab_done
    wr_byte(8'h80);
    stab_done = 1'b1; @(negedge clk); stab_done = 1'b0;
    chk("R7 mask held by enable", rd_data, 8'h82);

    // R3: reset origins
    lvl_chg = 1'b1; @(negedge clk); lvl_chg = 1'b0;
    rst = 1'b1; rst_by_det = 1'b1; @(negedge clk); rst = 1'b0; rst_by_det = 1'b0;
    chk("R3 detector reset keeps bit7", rd_data, 8'h82);
    wr_byte(8'h00);
    chk("R3 window cleared by reset", rd_data, 8'h00);
    wr_byte(8'h80);
    rst = 1'b1; @(negedge clk); rst = 1'b0;
    chk("R3 other reset clears", rd_data, 8'h00);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule